// File: doc/BRIEF.md
# Peripheral Event Trigger Fabric

This block lets a handful of small peripherals start one another while the processor sleeps. It has three producers with their own logic: a threshold comparator watching a sampled input, a down-counting timer, and a pulse counter that raises a wake interrupt after a programmed number of counted events. A fourth producer is the rising edge of a pulse input pin. Each producer emits only single-cycle trigger events. Events never carry data. A routing register connects each consumer action (timer start, DAC start strobe, pulse counter increment) to one producer or to none.

A typical chain routes the comparator event to the timer start and the timer-zero event to the DAC strobe. When the sample rises past the threshold, the DAC is started a programmed number of cycles later, and the processor does nothing. The pulse counter raises the interrupt line, and that line is its own cause, so software has no registers to poll. Software only writes the configuration, and it writes a clear to acknowledge the interrupt.

The state machines are these. The comparator has BELOW and ABOVE. A valid sample at or above the threshold moves BELOW to ABOVE, and this transition fires the event. A valid sample under the threshold moves ABOVE back to BELOW. The timer has IDLE and RUN. A start moves IDLE to RUN and loads the period. When the count is at one or below, RUN moves back to IDLE and fires the timer-zero event. The pulse counter has QUIET and FLAGGED. Reaching the target moves QUIET to FLAGGED. A clear write with no hit in the same cycle moves FLAGGED back to QUIET.

Top module: `trig_fabric`

## Requirements
- R1: After reset all three routing fields are zero (none), `dac_start` and `wake_irq` are low, and pulse-pin edges cause no DAC strobe.
- R2: The comparator fires once, when a valid sample lands at or above the threshold after the last valid sample was below it. It does not fire again while valid samples stay at or above the threshold. A sample is ignored while `smp_valid` is low.
- R3: A sample equal to the threshold counts as at or above it.
- R4: A routed start loads the period P into the timer. The timer-zero event follows max(P,1) cycles after the load cycle. With the comparator routed to the timer and the timer routed to the DAC, `dac_start` is high in the cycle that follows max(P,1)+2 rising edges, counted from the edge that captures the sample.
- R5: A start that arrives while the timer is running is ignored. A start after the timer returns to idle begins a new countdown.
- R6: A consumer whose routing code is 0, 5, 6 or 7 never fires.
- R7: The pulse counter emits its hit event and sets `wake_irq` on the N-th routed increment, where N is the programmed target. A target of 0 behaves as 1. The count returns to zero at the hit.
- R8: `wake_irq` stays high until a write to the clear address. It falls only because of such a write.
- R9: Every event and `dac_start` lasts exactly one cycle per firing.
- R10: Routing codes are 1 = comparator crossing, 2 = timer zero, 3 = rising edge of `pulse_in`, 4 = pulse-counter hit. Register addresses are 0 = threshold, 1 = timer period, 2 = pulse target, 3 = routing, 4 = interrupt clear. In the routing word, bits [2:0] select the timer start, bits [5:3] select the DAC strobe and bits [8:6] select the pulse-counter increment. A pulse-pin edge routed to the DAC strobes it in the cycle after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DW | Configuration write data |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sampled input value |
| pulse_in | input | 1 | Pulse input pin (synchronous) |
| dac_start | output | 1 | Single-cycle DAC start strobe |
| wake_irq | output | 1 | Sticky wake interrupt from the pulse counter |

## Verification
The bench sweeps the timer period from 0 through 6 and checks the exact cycle of the DAC strobe. An off-by-one in the load or the terminal count would move the strobe by a cycle, and a design that treats a zero period as a wrap would strobe far too late. The comparator is driven through a sequence that includes repeated samples above the threshold, a sample equal to the threshold, and a large value with the strobe low. A level-sensitive or strict-inequality comparator would give extra or missing strobes. The bench also retriggers the timer while it runs: a design that reloads would strobe late or twice. Pulse targets 1 through 5 are each run twice in a row with a clear between the runs. A counter that does not clear at the hit would raise the interrupt early in the second run, and an interrupt that is not sticky would drop before the clear write.

// File: rtl/trig_fabric_pkg.sv
package trig_fabric_pkg;
    // Producer codes selected by each routing field
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_CMP  = 3'd1,
        SRC_TMR  = 3'd2,
        SRC_PIN  = 3'd3,
        SRC_PCNT = 3'd4
    } src_e;

    localparam int SRC_W   = 3;
    localparam int N_CONS  = 3;
    // Consumer slots inside the routing word
    localparam int CON_TMR  = 0;
    localparam int CON_DAC  = 1;
    localparam int CON_PCNT = 2;

    // Register addresses
    localparam logic [2:0] A_THR   = 3'd0;
    localparam logic [2:0] A_PER   = 3'd1;
    localparam logic [2:0] A_TGT   = 3'd2;
    localparam logic [2:0] A_ROUTE = 3'd3;
    localparam logic [2:0] A_CLR   = 3'd4;

    typedef enum logic {C_BELOW, C_ABOVE}   cmp_st_e;
    typedef enum logic {T_IDLE, T_RUN}      tmr_st_e;
    typedef enum logic {P_QUIET, P_FLAGGED} pc_st_e;
endpackage

// File: rtl/thr_cmp.sv
module thr_cmp
    import trig_fabric_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] thr,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          rise_evt
);
    cmp_st_e state, nxt;
    logic    fire;
    logic    at_or_above;

    assign at_or_above = (smp_data >= thr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= C_BELOW;
            rise_evt <= 1'b0;
        end else begin
            state    <= nxt;
            rise_evt <= fire;
        end
    end

    always_comb begin
        nxt  = state;
        fire = 1'b0;
        if (smp_valid) begin
            unique case (state)
                C_BELOW: if (at_or_above) begin
                    nxt  = C_ABOVE;
                    fire = 1'b1;
                end
                C_ABOVE: if (!at_or_above) nxt = C_BELOW;
            endcase
        end
    end

    // R2: an event only follows a valid sample at or above threshold
    a_r2_evt_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |-> ($past(smp_valid) && ($past(smp_data) >= $past(thr))));
    // R9: crossing events never repeat on back-to-back cycles
    a_r9_cmp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> !rise_evt);
endmodule

// File: rtl/dn_timer.sv
module dn_timer
    import trig_fabric_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period,
    input  logic          start,
    output logic          zero_evt
);
    tmr_st_e       state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= T_IDLE;
            cnt      <= '0;
            zero_evt <= 1'b0;
        end else begin
            state    <= nxt;
            cnt      <= cnt_nxt;
            zero_evt <= fire;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        fire    = 1'b0;
        unique case (state)
            T_IDLE: if (start) begin
                nxt     = T_RUN;
                cnt_nxt = period;
            end
            T_RUN: if (cnt <= CW'(1)) begin
                nxt  = T_IDLE;
                fire = 1'b1;
            end else begin
                cnt_nxt = cnt - CW'(1);
            end
        endcase
    end

    // R5: a start while running does not reload the count
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_RUN && start && cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)));
    // R4: the zero event only ends a running countdown
    a_r4_zero_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> ($past(state) == T_RUN && state == T_IDLE));
endmodule

// File: rtl/pulse_cnt.sv
module pulse_cnt
    import trig_fabric_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] target,
    input  logic          inc,
    input  logic          clr,
    output logic          hit_evt,
    output logic          irq
);
    pc_st_e        state, nxt;
    logic [CW-1:0] count, count_nxt;
    logic [CW:0]   bumped;
    logic          hit;

    assign bumped = {1'b0, count} + (CW+1)'(1);
    assign hit    = inc && (bumped >= {1'b0, target});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= P_QUIET;
            count   <= '0;
            hit_evt <= 1'b0;
        end else begin
            state   <= nxt;
            count   <= count_nxt;
            hit_evt <= hit;
        end
    end

    always_comb begin
        count_nxt = count;
        if (hit)      count_nxt = '0;
        else if (inc) count_nxt = bumped[CW-1:0];
        nxt = state;
        unique case (state)
            P_QUIET:   if (hit) nxt = P_FLAGGED;
            P_FLAGGED: if (clr && !hit) nxt = P_QUIET;
        endcase
    end

    always_comb irq = (state == P_FLAGGED);

    // R7: a hit leaves the interrupt raised and the count at zero
    a_r7_hit_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        hit_evt |-> (irq && count == '0));
    // R8: without a clear the interrupt holds
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
endmodule

// File: rtl/trig_fabric.sv
module trig_fabric
    import trig_fabric_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          pulse_in,
    output logic          dac_start,
    output logic          wake_irq
);
    localparam int RW    = SRC_W * N_CONS;
    localparam int NSRC  = 1 << SRC_W;

    logic [DW-1:0]   thr_q, per_q, tgt_q;
    logic [RW-1:0]   route_q;
    logic            clr;
    logic            pin_q, pin_evt;
    logic            cmp_evt, tmr_evt, pc_evt;
    logic [NSRC-1:0] src_vec;
    logic [N_CONS-1:0] cons;

    assign clr = cfg_we && (cfg_addr == A_CLR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q   <= '0;
            per_q   <= '0;
            tgt_q   <= '0;
            route_q <= '0;
            pin_q   <= 1'b0;
            pin_evt <= 1'b0;
        end else begin
            pin_q   <= pulse_in;
            pin_evt <= pulse_in && !pin_q;
            if (cfg_we) begin
                unique case (cfg_addr)
                    A_THR:   thr_q   <= cfg_wdata;
                    A_PER:   per_q   <= cfg_wdata;
                    A_TGT:   tgt_q   <= cfg_wdata;
                    A_ROUTE: route_q <= cfg_wdata[RW-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Producer vector indexed by routing code; unused codes stay zero
    always_comb begin
        src_vec           = '0;
        src_vec[SRC_CMP]  = cmp_evt;
        src_vec[SRC_TMR]  = tmr_evt;
        src_vec[SRC_PIN]  = pin_evt;
        src_vec[SRC_PCNT] = pc_evt;
    end

    for (genvar c = 0; c < N_CONS; c++) begin : g_route
        assign cons[c] = src_vec[route_q[c*SRC_W +: SRC_W]];
    end

    thr_cmp #(.DW(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .thr(thr_q),
        .smp_valid(smp_valid), .smp_data(smp_data), .rise_evt(cmp_evt)
    );

    dn_timer #(.CW(DW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .period(per_q),
        .start(cons[CON_TMR]), .zero_evt(tmr_evt)
    );

    pulse_cnt #(.CW(DW)) u_pc (
        .clk(clk), .rst_n(rst_n), .target(tgt_q), .inc(cons[CON_PCNT]),
        .clr(clr), .hit_evt(pc_evt), .irq(wake_irq)
    );

    assign dac_start = cons[CON_DAC];

    // R6: an unrouted DAC field keeps the strobe low
    a_r6_dac_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q[CON_DAC*SRC_W +: SRC_W] == 3'd0 ||
         route_q[CON_DAC*SRC_W +: SRC_W] > 3'd4) |-> !dac_start);
    // R8: the interrupt falls only after a clear write
    a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_irq) |-> $past(clr));
    // R9: the pin edge event lasts one cycle
    a_r9_pin_single: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt |=> !pin_evt);
endmodule

// File: tb/trig_fabric_tb_top.sv
module trig_fabric_tb_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          pulse_in = 1'b0;
    logic          dac_start;
    logic          wake_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    trig_fabric #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
        .pulse_in(pulse_in), .dac_start(dac_start), .wake_irq(wake_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // kind 0: valid sample, 1: pin pulse, 2: data with valid low
    task automatic watch(input int kind, input int val, input int win,
                         output int lat, output int fires);
        lat = -1; fires = 0;
        @(negedge clk);
        if (kind == 1) pulse_in = 1'b1;
        else begin smp_data = DW'(val); smp_valid = (kind == 0); end
        for (int k = 1; k <= win; k++) begin
            @(negedge clk);
            smp_valid = 1'b0; pulse_in = 1'b0;
            if (dac_start) begin
                fires++;
                if (lat < 0) lat = k;
            end
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dac_start == 1'b0, "R1 dac_start", int'(dac_start), 0);
        chk(wake_irq == 1'b0, "R1 wake_irq", int'(wake_irq), 0);
        watch(1, 0, 4, lat, n);
        chk(n == 0, "R1 unrouted pulse", n, 0);

        // R10 pin routed straight to DAC
        wr(3'd3, 3 << 3);
        watch(1, 0, 4, lat, n);
        chk(lat == 1 && n == 1, "R10 pin->dac latency", lat, 1);

        // R2/R3 comparator crossing
        wr(3'd0, 100);
        wr(3'd3, 1 << 3);
        begin
            int vals[10] = '{50, 150, 200, 90, 100, 100, 99, 500, 101, 300};
            int kinds[10] = '{0, 0, 0, 0, 0, 0, 0, 2, 0, 0};
            int expf[10] = '{0, 1, 0, 0, 1, 0, 0, 0, 1, 0};
            for (int i = 0; i < 10; i++) begin
                watch(kinds[i], vals[i], 3, lat, n);
                chk(n == expf[i], (vals[i] == 100) ? "R3 equal threshold" : "R2 crossing count", n, expf[i]);
                if (expf[i] == 1) chk(lat == 1, "R2 crossing latency", lat, 1);
            end
        end

        // R4 timer period sweep: cmp -> timer start, timer zero -> DAC
        wr(3'd3, 1 | (2 << 3));
        for (int p = 0; p <= 6; p++) begin
            int e;
            e = ((p < 1) ? 1 : p) + 2;
            wr(3'd1, p);
            watch(0, 0, 2, lat, n);
            watch(0, 150, 14, lat, n);
            chk(lat == e, "R4 zero strobe cycle", lat, e);
            chk(n == 1, "R9 one strobe per countdown", n, 1);
        end

        // R5 retrigger while running is ignored: pin -> timer, timer -> DAC
        wr(3'd1, 6);
        wr(3'd3, 3 | (2 << 3));
        begin
            int first, last, cnt;
            first = -1; last = -1; cnt = 0;
            for (int i = 0; i < 26; i++) begin
                @(negedge clk);
                if (dac_start) begin
                    cnt++;
                    if (first < 0) first = i;
                    last = i;
                end
                pulse_in = (i == 0 || i == 3 || i == 12);
            end
            pulse_in = 1'b0;
            chk(cnt == 2, "R5 strobe count", cnt, 2);
            chk(first == 8, "R5 first strobe", first, 8);
            chk(last == 20, "R5 restart after idle", last, 20);
        end

        // R6 unrouted codes on the DAC field
        begin
            int codes[4] = '{0, 5, 6, 7};
            for (int i = 0; i < 4; i++) begin
                wr(3'd3, codes[i] << 3);
                watch(1, 0, 4, lat, n);
                chk(n == 0, "R6 unrouted code", n, 0);
            end
        end

        // R7/R8 pulse counter: pin -> increment, hit -> DAC
        wr(3'd3, (4 << 3) | (3 << 6));
        for (int t = 0; t <= 5; t++) begin
            int need;
            need = (t == 0) ? 1 : t;
            wr(3'd2, t);
            for (int r = 0; r < 2; r++) begin
                wr(3'd4, 0);
                chk(wake_irq == 1'b0, "R8 clear drops irq", int'(wake_irq), 0);
                for (int k = 1; k < need; k++) begin
                    watch(1, 0, 3, lat, n);
                    chk(wake_irq == 1'b0 && n == 0, "R7 no early hit", int'(wake_irq), 0);
                end
                watch(1, 0, 3, lat, n);
                chk(lat == 2 && n == 1, "R7 hit strobe", lat, 2);
                chk(wake_irq == 1'b1, "R7 irq raised", int'(wake_irq), 1);
                repeat (5) @(negedge clk);
                chk(wake_irq == 1'b1, "R8 irq sticky", int'(wake_irq), 1);
            end
        end
        wr(3'd4, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule